// File: doc/BRIEF.md
# Processor-to-PCI Address Translation Window

This block sits behind the processor's bus decoder and owns a 1 GiB aperture, 0x80000000 through 0xBFFFFFFF. Each read or write landing there becomes a single request on the PCI side. The request carries a command code, a PCI address, write data and byte enables. The block then waits for the PCI side to complete or abort the request, and returns the result to the processor. Requests outside the aperture are left to other decoders.

A configuration-select bit picks the kind of cycle. With the bit clear, the block issues memory cycles. The low 30 bits of the aperture offset pass through unchanged, and the top two PCI address bits come from a programmable field. With the bit set, the block issues type-0 configuration cycles. In that mode the offset is read as a one-hot device-select field starting at AD[13], a function number and a dword register index. Offsets that cannot name exactly one device end locally as a master abort, and no bus request is made.

A two-entry register port holds the control word and a sticky abort flag. Software clears the flag by writing a one to it.

Top module: `pci_xlate_window`

## Requirements
- R1: A request whose address is outside 0x80000000..0xBFFFFFFF causes no PCI request and no processor completion.
- R2: In memory mode the PCI address is the control word's bits 3:2 followed by the request's address bits 29:0.
- R3: Control word bit 1 selects the cycle type (0 memory, 1 configuration). The command code is 0x6 for a memory read, 0x7 for a memory write, 0xA for a configuration read and 0xB for a configuration write.
- R4: In configuration mode the PCI address keeps offset bits 19:13 (the one-hot device select) and bits 10:2 (function in 10:8, register index in 7:2). All other address bits, including 1:0 and 12:11, are zero.
- R5: A configuration request whose offset is 0x100000 or higher, or whose bits 19:13 do not have exactly one bit set, issues no PCI request. It completes in the cycle after acceptance with the error flag set, read data 0xFFFFFFFF, and the abort flag set.
- R6: A PCI abort completes the request with the error flag set and read data 0xFFFFFFFF, and sets the sticky abort flag (bit 0 of status register, select 1). Writing 1 to status bit 0 clears the flag. Writing 0 to it leaves the flag unchanged.
- R7: Byte enables (bit n enables byte lane n) follow the size code and address bits 1:0. Size 0 (byte) enables lane addr[1:0]. Size 1 (half) enables lanes 1:0 or 3:2 by addr[1]. Sizes 2 and 3 enable all four lanes.
- R8: A control-word write takes effect from the next accepted request. Read-back returns the new value at once, while the outstanding PCI request keeps its command and address.
- R9: The PCI request stays valid with stable fields until ack or abort. The processor completion is a one-cycle pulse in the cycle after ack, and carries the PCI read data.
- R10: After reset both registers read zero and no request or completion is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_done |
| cpu_write | input | 1 | 1 = write |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 0 byte, 1 half, 2/3 word |
| cpu_wdata | input | 32 | Write data, lane-aligned |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Completion ended in abort |
| cpu_rdata | output | 32 | Read data on completion |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 control word, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read-back of selected entry |
| pci_valid | output | 1 | PCI request outstanding |
| pci_cmd | output | 4 | PCI command code |
| pci_addr | output | 32 | PCI address |
| pci_be | output | 4 | Byte enables, active high |
| pci_wdata | output | 32 | Write data |
| pci_ack | input | 1 | Target completed the request |
| pci_abort | input | 1 | No target response |
| pci_rdata | input | 32 | Read data, valid with pci_ack |

## Verification
Memory cycles are run with the upper-bit field at zero and at its maximum, and with byte, halfword and word sizes at several lane offsets. These separate the address pass-through from the upper-bit splice and from the byte-enable decode. Configuration cycles are run at the lowest and highest device, with junk in offset bits 12:11 and 1:0, which shows which offset bits are dropped. Out-of-range, no-select and two-select offsets each end in a local abort, while a target abort ends on the bus; the two paths are told apart by whether a PCI request ever appears. A mode flip during an outstanding request shows that the current request is unaffected while the next one changes.

// File: rtl/pci_xlate_window.sv
module pci_xlate_window #(
  parameter int IDSEL_LO = 13,
  parameter int CFG_BITS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  input  logic        cpu_write,
  input  logic [31:0] cpu_addr,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_done,
  output logic        cpu_err,
  output logic [31:0] cpu_rdata,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pci_valid,
  output logic [3:0]  pci_cmd,
  output logic [31:0] pci_addr,
  output logic [3:0]  pci_be,
  output logic [31:0] pci_wdata,
  input  logic        pci_ack,
  input  logic        pci_abort,
  input  logic [31:0] pci_rdata
);
  localparam int NDEV = CFG_BITS - IDSEL_LO;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RESP} st_t;
  st_t state;

  logic       cfg_mode;
  logic [1:0] hi_bits;
  logic       abort_flag;

  wire        hit   = (cpu_addr[31:30] == 2'b10);
  wire [29:0] off   = cpu_addr[29:0];
  wire [NDEV-1:0] idsel = off[CFG_BITS-1:IDSEL_LO];
  wire        sel_one  = (idsel != '0) && ((idsel & (idsel - 1'b1)) == '0);
  wire        cfg_ok   = (off[29:CFG_BITS] == '0) && sel_one;
  wire        accept   = (state == S_IDLE) && cpu_valid && hit;
  wire        local_ab = accept && cfg_mode && !cfg_ok;
  wire        bus_ab   = (state == S_BUS) && pci_abort;
  wire        flag_clr = reg_we && reg_sel && reg_wdata[0];
  wire        unused_wdata = &{1'b0, reg_wdata[31:4]};

  logic [3:0]  be_c;
  logic [31:0] addr_c;

  always_comb begin
    case (cpu_size)
      2'd0:    be_c = 4'b0001 << cpu_addr[1:0];
      2'd1:    be_c = cpu_addr[1] ? 4'b1100 : 4'b0011;
      default: be_c = 4'b1111;
    endcase
  end

  assign addr_c = cfg_mode
    ? {{(32-CFG_BITS){1'b0}}, idsel, {(IDSEL_LO-11){1'b0}}, off[10:2], 2'b00}
    : {hi_bits, off};

  assign pci_valid = (state == S_BUS);
  assign cpu_done  = (state == S_RESP);
  assign reg_rdata = reg_sel ? {31'b0, abort_flag} : {28'b0, hi_bits, cfg_mode, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      hi_bits  <= 2'b00;
    end else if (reg_we && !reg_sel) begin
      cfg_mode <= reg_wdata[1];
      hi_bits  <= reg_wdata[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) abort_flag <= 1'b0;
    else if (local_ab || bus_ab) abort_flag <= 1'b1;
    else if (flag_clr) abort_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pci_cmd   <= 4'h0;
      pci_addr  <= '0;
      pci_be    <= 4'h0;
      pci_wdata <= '0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (local_ab) begin
            state     <= S_RESP;
            cpu_err   <= 1'b1;
            cpu_rdata <= '1;
          end else if (accept) begin
            state     <= S_BUS;
            pci_cmd   <= cfg_mode ? {3'b101, cpu_write} : {3'b011, cpu_write};
            pci_addr  <= addr_c;
            pci_be    <= be_c;
            pci_wdata <= cpu_wdata;
          end
        end
        S_BUS: begin
          if (pci_abort) begin
            state     <= S_RESP;
            cpu_err   <= 1'b1;
            cpu_rdata <= '1;
          end else if (pci_ack) begin
            state     <= S_RESP;
            cpu_err   <= 1'b0;
            cpu_rdata <= pci_rdata;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module pci_xlate_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic [31:0] cpu_addr,
  input logic        cpu_done,
  input logic        cpu_err,
  input logic [31:0] cpu_rdata,
  input logic        pci_valid,
  input logic [3:0]  pci_cmd,
  input logic [31:0] pci_addr,
  input logic [3:0]  pci_be,
  input logic        pci_ack,
  input logic        pci_abort
);
  p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_addr[31:30] != 2'b10 && !pci_valid && !cpu_done |=> !pci_valid && !cpu_done);

  p_cmd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> (pci_cmd == 4'h6 || pci_cmd == 4'h7 || pci_cmd == 4'hA || pci_cmd == 4'hB));

  p_cfg_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_cmd[3] |-> $countones(pci_addr[19:13]) == 1 && pci_addr[31:20] == 12'h0
                                && pci_addr[12:11] == 2'b00 && pci_addr[1:0] == 2'b00);

  p_abort_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_abort |=> cpu_done && cpu_err && cpu_rdata == 32'hFFFFFFFF);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_ack && !pci_abort |=> pci_valid && $stable(pci_addr) && $stable(pci_cmd) && $stable(pci_be));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_done && pci_valid));
endmodule

bind pci_xlate_window pci_xlate_window_chk u_chk (.*);

// File: tb/pci_xlate_window_tb.sv
`timescale 1ns/1ps
module pci_xlate_window_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_valid = 0, cpu_write = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [1:0]  cpu_size = 0;
  logic        cpu_done, cpu_err;
  logic [31:0] cpu_rdata;
  logic        reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        pci_valid;
  logic [3:0]  pci_cmd, pci_be;
  logic [31:0] pci_addr, pci_wdata;
  logic        pci_ack = 0, pci_abort = 0;
  logic [31:0] pci_rdata = 0;

  int checks = 0, fails = 0;
  bit m_cfg = 0;
  int m_hi = 0;
  bit m_abort = 0;

  always #2.5 clk = ~clk;

  pci_xlate_window u_dut (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic reg_write(input bit sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1;
    step();
    reg_we = 0;
    if (!sel) begin m_cfg = d[1]; m_hi = int'(d[3:2]); end
    else if (d[0]) m_abort = 0;
  endtask

  task automatic reg_check(input bit sel, input string rq);
    logic [31:0] e;
    reg_sel = sel; #0.1;
    e = sel ? {31'b0, m_abort} : (32'(m_hi) << 2) | (32'(m_cfg) << 1);
    chk(reg_rdata == e, rq, "register read-back", reg_rdata, e);
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int lat, input bit do_abort,
                        input logic [31:0] trd, input bit flip, input string rq);
    bit inwin, legal;
    logic [31:0] off, eaddr, erd;
    logic [3:0] ecmd, ebe;
    int cnt, dev;
    inwin = (a >= 32'h8000_0000) && (a <= 32'hBFFF_FFFF);
    cpu_write = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd; cpu_valid = 1;
    if (!inwin) begin
      for (int i = 0; i < 3; i++) begin
        step();
        chk(!pci_valid && !cpu_done, rq, "out-of-window activity", {pci_valid, cpu_done}, 0);
      end
      cpu_valid = 0;
      step();
      return;
    end
    off = a - 32'h8000_0000;
    cnt = 0; dev = 0;
    for (int d = 0; d < 7; d++) if (off[13+d]) begin cnt++; dev = d; end
    if (m_cfg) begin
      legal = (off < 32'h0010_0000) && (cnt == 1);
      eaddr = (32'd1 << (13 + dev)) + ((off >> 8) & 7) * 256 + ((off >> 2) & 63) * 4;
      ecmd = wr ? 4'hB : 4'hA;
    end else begin
      legal = 1;
      eaddr = (32'(m_hi) << 30) | off;
      ecmd = wr ? 4'h7 : 4'h6;
    end
    ebe = (sz == 0) ? (4'b0001 << a[1:0]) : (sz == 1) ? (a[1] ? 4'hC : 4'h3) : 4'hF;
    step();
    if (!legal) begin
      chk(!pci_valid, rq, "no bus request on local abort", pci_valid, 0);
      chk(cpu_done && cpu_err, rq, "local abort completion", {cpu_done, cpu_err}, 3);
      chk(cpu_rdata == 32'hFFFF_FFFF, rq, "local abort data", cpu_rdata, 32'hFFFF_FFFF);
      m_abort = 1;
    end else begin
      chk(pci_valid, rq, "request issued", pci_valid, 1);
      chk(pci_cmd == ecmd, rq, "command", pci_cmd, ecmd);
      chk(pci_addr == eaddr, rq, "PCI address", pci_addr, eaddr);
      chk(pci_be == ebe, rq, "byte enables", pci_be, ebe);
      if (wr) chk(pci_wdata == wd, rq, "write data", pci_wdata, wd);
      if (flip) begin
        reg_write(0, 32'h0);
        reg_check(0, "R8");
        chk(pci_valid && pci_cmd == ecmd, "R8", "outstanding command kept", pci_cmd, ecmd);
        chk(pci_addr == eaddr, "R8", "outstanding address kept", pci_addr, eaddr);
      end
      for (int i = 0; i < lat; i++) begin
        step();
        chk(pci_valid && pci_addr == eaddr && !cpu_done, "R9", "request held", pci_addr, eaddr);
      end
      pci_rdata = trd;
      if (do_abort) pci_abort = 1; else pci_ack = 1;
      step();
      pci_ack = 0; pci_abort = 0;
      erd = do_abort ? 32'hFFFF_FFFF : trd;
      chk(cpu_done && !pci_valid, rq, "completion pulse", {cpu_done, pci_valid}, 2);
      chk(cpu_err == do_abort, rq, "completion error", cpu_err, do_abort);
      if (!wr || do_abort) chk(cpu_rdata == erd, rq, "completion data", cpu_rdata, erd);
      if (do_abort) m_abort = 1;
    end
    cpu_valid = 0;
    step();
    chk(!cpu_done && !pci_valid, "R9", "idle after completion", {cpu_done, pci_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!pci_valid && !cpu_done, "R10", "no activity after reset", {pci_valid, cpu_done}, 0);
    reg_check(0, "R10");
    reg_check(1, "R10");
    // R1 outside the window
    access(0, 32'h4000_1000, 2, 0, 1, 0, 0, 0, "R1");
    access(1, 32'hC000_0000, 2, 32'h1, 1, 0, 0, 0, "R1");
    // R2 R3 R9 memory read, upper bits zero
    access(0, 32'h8000_1230, 2, 0, 2, 0, 32'hCAFE_F00D, 0, "R2");
    // R2 R7 upper bits 3, byte write lane 1
    reg_write(0, 32'hC);
    reg_check(0, "R2");
    access(1, 32'h9ABC_DE01, 0, 32'h0000_5500, 1, 0, 0, 0, "R7");
    access(1, 32'h8000_0102, 1, 32'hBEEF_0000, 0, 0, 0, 0, "R7");
    access(0, 32'hBFFF_FFFC, 3, 0, 0, 0, 32'h1234_5678, 0, "R2");
    // R3 R4 configuration cycles
    reg_write(0, 32'h2);
    reg_check(0, "R3");
    access(0, 32'h8000_3A13, 2, 0, 1, 0, 32'h0000_ABCD, 0, "R4");
    access(1, 32'h8008_07FD, 0, 32'h0000_7700, 1, 0, 0, 0, "R4");
    // R5 local aborts
    access(0, 32'h8010_2000, 2, 0, 0, 0, 0, 0, "R5");
    reg_check(1, "R5");
    reg_write(1, 32'h0);
    reg_check(1, "R6");
    reg_write(1, 32'h1);
    reg_check(1, "R6");
    access(0, 32'h8000_0010, 2, 0, 0, 0, 0, 0, "R5");
    access(1, 32'h8000_6000, 2, 32'h5, 0, 0, 0, 0, "R5");
    reg_write(1, 32'h1);
    reg_check(1, "R6");
    // R6 target abort on configuration read
    access(0, 32'h8000_4004, 2, 0, 2, 1, 32'h1111_1111, 0, "R6");
    reg_check(1, "R6");
    reg_write(1, 32'h1);
    reg_check(1, "R6");
    // R8 mode flip while a request is outstanding
    access(0, 32'h8000_2008, 2, 0, 1, 0, 32'h2222_3333, 1, "R8");
    access(0, 32'h8000_2008, 2, 0, 1, 0, 32'h4444_5555, 0, "R8");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule